// File: doc/BRIEF.md
# Complementary Triangle PWM with Guarded Synchronous Restart

This block produces a complementary pair of active-low PWM outputs from two triangle counters. Both counters sweep between zero and a programmed peak. One of them (the leading counter) runs a fixed number of cycles, the dead time, ahead of the other (the lagging counter). The positive-phase output is driven active while the duty threshold lies above both counters. The negative-phase output is driven active while the threshold lies below both. The spread between the two counters therefore opens a dead-time gap around every crossing, so the two outputs are never active together.

After a start, and after a forced restart, the outputs hold programmed idle levels for one dead-time span before they follow the compare result. A synchronous clear request from another timer reloads both counters to the start-of-trough position. If the request lands outside the trough interval, or inside the idle span that follows a start, the idle span is forced again. If it lands inside the trough interval and suppression is enabled, the counters reload without forcing the idle levels, so the duty cycle moves without an abrupt step. Configuration is captured only while the generator is stopped.

Top module: `cpwm_sync_guard`

## Requirements
- R1: After reset, and whenever the generator is stopped, pwm_pos_n equals the programmed positive idle level and pwm_neg_n equals the programmed negative idle level. Both idle levels reset to 1, which is the inactive level.
- R2: A configuration write (cfg_we=1) is captured only in a cycle where run_i=0 and the generator was already stopped. A write attempted while running has no effect on the outputs.
- R3: When run_i rises, the counters load their start values. For the next `dead` running cycles, both outputs show their idle levels.
- R4: Counting from its load value, each counter climbs by 1 per running cycle up to `period`, then falls by 1 per cycle to 0, then climbs again. The leading counter loads 1 (rising) and the lagging counter loads dead−1 (falling), so the lagging counter trails the leading one by exactly `dead` cycles.
- R5: Outside the idle span, pwm_pos_n is 0 exactly when max(lead, lag) < duty, and pwm_neg_n is 0 exactly when min(lead, lag) > duty.
- R6: Outside the idle span, pwm_pos_n and pwm_neg_n are never 0 together.
- R7: A sync_clr_i pulse while running and outside the trough interval reloads both counters and restarts the idle span of `dead` cycles, whatever the value of cfg_supp_en. The trough interval is the set of cycles where the leading counter is rising and the lagging counter is falling.
- R8: A sync_clr_i pulse inside the trough interval, with cfg_supp_en=1 and no idle span in progress, reloads both counters but does not start an idle span. The outputs keep following R5.
- R9: A sync_clr_i pulse inside the trough interval with cfg_supp_en=0 behaves as in R7.
- R10: A sync_clr_i pulse during an idle span forces a fresh idle span even when it is in the trough interval and cfg_supp_en=1.
- R11: sync_clr_i has no effect while the generator is stopped. The outputs stay idle, and the next start behaves as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration capture strobe |
| cfg_period | input | CW | Triangle peak value (≥2) |
| cfg_dead | input | CW | Dead-time count (1 ≤ dead < period) |
| cfg_duty | input | CW | Duty threshold |
| cfg_idle_pos | input | 1 | Idle level of the positive-phase output |
| cfg_idle_neg | input | 1 | Idle level of the negative-phase output |
| cfg_supp_en | input | 1 | Enable suppression of the idle span for clears in the trough |
| run_i | input | 1 | Run level; a rising edge starts the generator |
| sync_clr_i | input | 1 | Synchronous clear request from another timer |
| pwm_pos_n | output | 1 | Positive-phase output, active low |
| pwm_neg_n | output | 1 | Negative-phase output, active low |

## Verification
A wrong counter direction or turn point shows on the outputs within half a triangle period, as an edge displaced against the arithmetic triangle. A miscounted idle span shows within `dead` cycles of a start or clear, as idle levels held one cycle too long or too short. A misjudged trough interval shows in the first cycle after a clear: either an idle span appears where none was due, or the compare result appears where idle levels were due. Comparing both outputs every cycle while sweeping dead time, duty, suppression and the clear's offset within the period catches each of these at the first affected cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } cnt_dir_e;

  localparam int NUM_CNT  = 2;
  localparam int LAG_IDX  = 0;
  localparam int LEAD_IDX = 1;
endpackage

// File: rtl/cpwm_tri_counter.sv
module cpwm_tri_counter
  import cpwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  cnt_dir_e      load_dir,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          up
);
  logic [CW-1:0] cnt_q, cnt_d;
  cnt_dir_e      dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (load) begin
      cnt_d = load_val;
      dir_d = load_dir;
    end else if (en) begin
      if (dir_q == DIR_UP) begin
        if (cnt_q >= limit) begin
          dir_d = DIR_DN;
          cnt_d = limit - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          dir_d = DIR_UP;
          cnt_d = {{(CW-1){1'b0}}, 1'b1};
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt = cnt_q;
  assign up  = (dir_q == DIR_UP);

  // R4: a running counter never leaves the 0..limit range
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= limit));

  // R4: reaching the peak while rising turns the counter downward
  a_r4_turn_at_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && dir_q == DIR_UP && cnt_q == limit) |=> (dir_q == DIR_DN));
endmodule

// File: rtl/cpwm_guard_window.sv
module cpwm_guard_window #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic          sync_clr,
  input  logic          supp_en,
  input  logic [CW-1:0] dead,
  input  logic          lead_up,
  input  logic          lag_up,
  output logic          reload,
  output logic          init_active
);
  logic [CW-1:0] init_q, init_d;
  logic          trough, clr_hit, shield, force_idle;

  assign trough      = lead_up && !lag_up;
  assign init_active = (init_q != '0);
  assign clr_hit     = run && sync_clr;
  assign shield      = supp_en && trough && !init_active;
  assign force_idle  = clr_hit && !shield;
  assign reload      = start || clr_hit;

  always_comb begin
    init_d = init_q;
    if (start || force_idle) begin
      init_d = dead;
    end else if (run && init_active) begin
      init_d = init_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= '0;
    else        init_q <= init_d;
  end

  // R7, R9: a clear outside the shielded case restarts the idle span
  a_r7_forced_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync_clr && !(supp_en && lead_up && !lag_up && init_active == 1'b0))
      |=> (init_q == dead));

  // R8: a shielded clear in the trough starts no idle span
  a_r8_shielded_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync_clr && supp_en && lead_up && !lag_up && init_q == '0)
      |=> (init_q == '0));

  // R10: a clear during the idle span keeps the idle span alive
  a_r10_init_reforced: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync_clr && init_q != '0) |=> (init_q != '0));
endmodule

// File: rtl/cpwm_phase_drive.sv
module cpwm_phase_drive #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          idle_pos,
  input  logic          idle_neg,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  output logic          pos_n,
  output logic          neg_n
);
  logic [CW-1:0] hi, lo;
  logic          pos_act, neg_act;

  assign hi      = (cnt_a > cnt_b) ? cnt_a : cnt_b;
  assign lo      = (cnt_a > cnt_b) ? cnt_b : cnt_a;
  assign pos_act = (hi < duty);
  assign neg_act = (lo > duty);

  always_comb begin
    if (idle) begin
      pos_n = idle_pos;
      neg_n = idle_neg;
    end else begin
      pos_n = !pos_act;
      neg_n = !neg_act;
    end
  end

  // R6: the complementary pair is never active together while comparing
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (pos_n || neg_n));
endmodule

// File: rtl/cpwm_sync_guard.sv
module cpwm_sync_guard
  import cpwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_dead,
  input  logic [CW-1:0] cfg_duty,
  input  logic          cfg_idle_pos,
  input  logic          cfg_idle_neg,
  input  logic          cfg_supp_en,
  input  logic          run_i,
  input  logic          sync_clr_i,
  output logic          pwm_pos_n,
  output logic          pwm_neg_n
);
  logic [1:0]    rst_pipe;
  logic          rst_sn;
  logic          run_q, start, cfg_open;
  logic [CW-1:0] period_q, dead_q, duty_q;
  logic          idle_pos_q, idle_neg_q, supp_q;
  logic          reload, init_active, idle;

  logic [CW-1:0] load_val [NUM_CNT];
  cnt_dir_e      load_dir [NUM_CNT];
  logic [CW-1:0] cnt_val  [NUM_CNT];
  logic          cnt_up   [NUM_CNT];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) run_q <= 1'b0;
    else         run_q <= run_i;
  end
  assign start    = run_i && !run_q;
  assign cfg_open = cfg_we && !run_i && !run_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      period_q   <= '0;
      dead_q     <= '0;
      duty_q     <= '0;
      idle_pos_q <= 1'b1;
      idle_neg_q <= 1'b1;
      supp_q     <= 1'b0;
    end else if (cfg_open) begin
      period_q   <= cfg_period;
      dead_q     <= cfg_dead;
      duty_q     <= cfg_duty;
      idle_pos_q <= cfg_idle_pos;
      idle_neg_q <= cfg_idle_neg;
      supp_q     <= cfg_supp_en;
    end
  end

  // start-of-trough position: leading counter rising from 1, lagging one falling
  assign load_val[LEAD_IDX] = {{(CW-1){1'b0}}, 1'b1};
  assign load_dir[LEAD_IDX] = DIR_UP;
  assign load_val[LAG_IDX]  = dead_q - 1'b1;
  assign load_dir[LAG_IDX]  = DIR_DN;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    cpwm_tri_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_sn),
      .en       (run_q),
      .load     (reload),
      .load_val (load_val[g]),
      .load_dir (load_dir[g]),
      .limit    (period_q),
      .cnt      (cnt_val[g]),
      .up       (cnt_up[g])
    );
  end

  cpwm_guard_window #(.CW(CW)) u_window (
    .clk         (clk),
    .rst_n       (rst_sn),
    .run         (run_q),
    .start       (start),
    .sync_clr    (sync_clr_i),
    .supp_en     (supp_q),
    .dead        (dead_q),
    .lead_up     (cnt_up[LEAD_IDX]),
    .lag_up      (cnt_up[LAG_IDX]),
    .reload      (reload),
    .init_active (init_active)
  );

  assign idle = !run_q || init_active;

  cpwm_phase_drive #(.CW(CW)) u_drive (
    .clk      (clk),
    .rst_n    (rst_sn),
    .idle     (idle),
    .idle_pos (idle_pos_q),
    .idle_neg (idle_neg_q),
    .duty     (duty_q),
    .cnt_a    (cnt_val[LEAD_IDX]),
    .cnt_b    (cnt_val[LAG_IDX]),
    .pos_n    (pwm_pos_n),
    .neg_n    (pwm_neg_n)
  );

  // R2: captured configuration holds while the generator runs
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_sn)
    run_q |=> ($stable(duty_q) && $stable(dead_q) && $stable(period_q)));

  // R1, R11: a stopped generator shows its idle levels
  a_r1_stopped_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    !run_q |-> (pwm_pos_n == idle_pos_q && pwm_neg_n == idle_neg_q));
endmodule

// File: tb/cpwm_sync_guard_tb.sv
`timescale 1ns/1ps
module cpwm_sync_guard_tb_top;
  localparam int CW = 8;
  localparam int T  = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_idle_pos, cfg_idle_neg, cfg_supp_en, run_i, sync_clr_i;
  logic [CW-1:0] cfg_period, cfg_dead, cfg_duty;
  logic          pwm_pos_n, pwm_neg_n;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cpwm_sync_guard #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_period(cfg_period),
    .cfg_dead(cfg_dead), .cfg_duty(cfg_duty), .cfg_idle_pos(cfg_idle_pos),
    .cfg_idle_neg(cfg_idle_neg), .cfg_supp_en(cfg_supp_en), .run_i(run_i),
    .sync_clr_i(sync_clr_i), .pwm_pos_n(pwm_pos_n), .pwm_neg_n(pwm_neg_n)
  );

  // arithmetic reference state
  int m_run, m_ph, m_init, m_per, m_dead, m_duty, m_ipos, m_ineg, m_supp;
  int init_tag, run_tag;

  function automatic int fold(int m, int per);
    return (m <= per) ? m : 2 * per - m;
  endfunction
  function automatic int rising(int m, int per);
    return (m >= 1 && m <= per) ? 1 : 0;
  endfunction
  function automatic int lead_m(int ph, int per);
    return (ph + 1) % (2 * per);
  endfunction
  function automatic int lag_m(int ph, int per, int dt);
    return (ph + 1 - dt + 2 * per) % (2 * per);
  endfunction
  function automatic string tname(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; 11: return "R11";
      default: return "R4 R5";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_ph <= 0; m_init <= 0; m_per <= 0; m_dead <= 0; m_duty <= 0;
      m_ipos <= 1; m_ineg <= 1; m_supp <= 0; init_tag <= 3; run_tag <= 45;
    end else begin
      int trough, shield, frc, strt, clr;
      strt   = (run_i && m_run == 0) ? 1 : 0;
      clr    = (m_run != 0 && sync_clr_i) ? 1 : 0;
      trough = (rising(lead_m(m_ph, m_per), m_per) == 1 &&
                rising(lag_m(m_ph, m_per, m_dead), m_per) == 0) ? 1 : 0;
      shield = (m_supp != 0 && trough == 1 && m_init == 0) ? 1 : 0;
      frc    = (clr == 1 && shield == 0) ? 1 : 0;
      if (cfg_we && !run_i && m_run == 0) begin
        m_per <= int'(cfg_period); m_dead <= int'(cfg_dead); m_duty <= int'(cfg_duty);
        m_ipos <= int'(cfg_idle_pos); m_ineg <= int'(cfg_idle_neg); m_supp <= int'(cfg_supp_en);
      end
      if (cfg_we && (run_i || m_run != 0)) run_tag <= 2;
      if (strt == 1 || clr == 1) m_ph <= 0;
      else if (m_run != 0)       m_ph <= m_ph + 1;
      if (strt == 1 || frc == 1) m_init <= m_dead;
      else if (m_run != 0 && m_init > 0) m_init <= m_init - 1;
      if (strt == 1) begin init_tag <= 3; run_tag <= 45; end
      if (frc == 1) begin
        init_tag <= (m_init > 0) ? 10 : (trough == 1 ? 9 : 7);
        run_tag  <= 45;
      end
      if (shield == 1 && clr == 1) run_tag <= 8;
      m_run <= run_i ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ep, en, tg, hi, lo, a, b;
    if (m_run == 0) begin
      ep = m_ipos; en = m_ineg; tg = 1;
    end else if (m_init > 0) begin
      ep = m_ipos; en = m_ineg; tg = init_tag;
    end else begin
      a  = fold(lead_m(m_ph, m_per), m_per);
      b  = fold(lag_m(m_ph, m_per, m_dead), m_per);
      hi = (a > b) ? a : b;
      lo = (a > b) ? b : a;
      ep = (hi < m_duty) ? 0 : 1;
      en = (lo > m_duty) ? 0 : 1;
      tg = run_tag;
      // R6: never both active while comparing
      chk(pwm_pos_n || pwm_neg_n, "R6", {pwm_pos_n, pwm_neg_n}, 1);
    end
    chk(int'(pwm_pos_n) == ep, {tname(tg), " pos"}, int'(pwm_pos_n), ep);
    chk(int'(pwm_neg_n) == en, {tname(tg), " neg"}, int'(pwm_neg_n), en);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_period = '0; cfg_dead = '0; cfg_duty = '0;
    cfg_idle_pos = 0; cfg_idle_neg = 0; cfg_supp_en = 0; run_i = 0; sync_clr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset levels are the inactive level 1 on both outputs
    chk(pwm_pos_n == 1'b1, "R1 reset pos", int'(pwm_pos_n), 1);
    chk(pwm_neg_n == 1'b1, "R1 reset neg", int'(pwm_neg_n), 1);

    for (int dt = 1; dt <= 3; dt++) begin
      for (int du = 0; du <= T + 1; du++) begin
        for (int sp = 0; sp <= 1; sp++) begin
          run_i = 0;
          step();
          cfg_we = 1; cfg_period = CW'(T); cfg_dead = CW'(dt); cfg_duty = CW'(du);
          cfg_idle_pos = 1; cfg_idle_neg = du[0]; cfg_supp_en = sp[0];
          step();
          cfg_we = 0;
          // R11: clear while stopped changes nothing
          sync_clr_i = 1;
          step();
          sync_clr_i = 0;
          chk(pwm_pos_n == 1'b1, "R11 pos", int'(pwm_pos_n), 1);
          chk(int'(pwm_neg_n) == du % 2, "R11 neg", int'(pwm_neg_n), du % 2);
          run_i = 1;
          repeat (4 * T + dt + 2) step();
          // R2: write while running is ignored
          cfg_we = 1; cfg_duty = CW'(T - du + 1); cfg_dead = CW'(4 - dt);
          repeat (3) step();
          cfg_we = 0;
          repeat (2 * T) step();
          for (int off = 0; off < 2 * T; off++) begin
            repeat (off) step();
            sync_clr_i = 1;
            step();
            sync_clr_i = 0;
            repeat (2 * T) step();
          end
          // R10: clear inside the start-up idle span
          run_i = 0;
          step();
          run_i = 1;
          step();
          sync_clr_i = 1;
          step();
          sync_clr_i = 0;
          repeat (2 * T) step();
        end
      end
    end
    done = 1;
    summary();
    $finish;
  end
endmodule